// File: doc/BRIEF.md
# Write-back cache controller

This block is a memory system front end with one level of cache. A requester presents a 16-bit byte address with a read strobe or a write strobe. The block holds a direct-mapped cache of four-word lines, each line with a tag, a valid bit and a dirty bit, and a controller state machine. A miss to a clean slot fetches the line from a behavioural main memory. That memory has four word-interleaved banks and a fixed access latency. A miss to a dirty slot first streams the four victim words back to memory on consecutive cycles and then fetches the new line. Writes follow a write-back, write-allocate policy: the store word is merged into the line while the refill is in progress.

Back-pressure uses `stall`, which acts as an inverted ready. A strobe is taken only in a cycle where `stall` is low. While `stall` is high, the strobes, address and data inputs are not looked at. `done` marks the one cycle in which a request completes; `rdata` is valid in that cycle for reads. The word address has three parts. Bits [2:1] select the word within a line, and also the memory bank. Bits [2+INDEX_W:3] select the slot. The bits above them form the tag. Bit 0 must be zero.

Top module: `cwb_mem_system`

## Requirements
- R1: After reset `done`, `stall`, `err` and `cache_hit` are low and every slot is invalid, so the first access to any line misses.
- R2: A read hit raises `done` and `cache_hit` in the same cycle as the strobe, with the addressed word on `rdata`.
- R3: A write hit completes in the strobe cycle with `done` and `cache_hit` high, updates the word and marks the line dirty, so a later eviction writes it back.
- R4: A read miss to an invalid or clean slot keeps `cache_hit` low and raises `done` exactly 8 cycles after the strobe cycle. The four refill reads go out on consecutive cycles, each returning 4 cycles later in word order 0 to 3.
- R5: A write miss fetches the line, merges the store word into it, and leaves the line dirty. It completes on the same 8-cycle schedule as R4.
- R6: A miss to a dirty slot writes the four victim words to their banks on four consecutive cycles before the refill. `done` comes 12 cycles after the strobe cycle, and the evicted data reads back correctly later.
- R7: `done` is high for exactly one cycle per accepted request. `stall` is high from the cycle after a miss is detected through the cycle in which `done` is high, and low in the following cycle.
- R8: While `stall` is high, strobe, address and data inputs have no effect: no extra `done`, no `err`, and no change to cache or memory contents.
- R9: A strobe cycle with address bit 0 set, or with both strobes high, raises `err` for that cycle without `done` and changes no state. A request to a bank that is still busy also raises `err`.
- R10: The memory model holds 2^MEM_AW words. At reset, word w holds (w*0x9E37 xor 0x5A5A) mod 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 16 | Byte address, word aligned |
| wdata | input | 16 | Store data |
| rdata | output | 16 | Load data, valid with `done` on reads |
| done | output | 1 | Request completes this cycle |
| stall | output | 1 | Busy; inputs are ignored while high |
| cache_hit | output | 1 | The completing request hit |
| err | output | 1 | Malformed request or bank conflict |

## Verification
A wrong tag, valid or dirty bit changes the hit/miss outcome. That shows at the ports at once as a wrong `cache_hit` and a completion latency of 0, 8 or 12 cycles that does not match the model. A lost dirty bit, or a victim word written to the wrong bank, does not show until that line is evicted and read again, when stale data comes back. So the stimulus concentrates addresses on few tags and forces conflicts. Stray inputs are driven during every stall so that any leak from them shows up as corrupted data or an unexpected `done`.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL, ST_WAIT} cwb_state_e;

  // preset contents of main memory word w
  function automatic logic [15:0] cwb_seed_word(input logic [31:0] w);
    logic [31:0] p;
    p = (w * 32'h9E37) ^ 32'h5A5A;
    return p[15:0];
  endfunction
endpackage

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic               rd_dirty,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               we,
  input  logic [INDEX_W-1:0] w_idx,
  input  logic [TAG_W-1:0]   w_tag,
  input  logic               w_dirty
);
  localparam int SLOTS = 1 << INDEX_W;

  logic [SLOTS-1:0] valid_q;
  logic [SLOTS-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (we) begin
      valid_q[w_idx] <= 1'b1;
      dirty_q[w_idx] <= w_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (we) tag_q[w_idx] <= w_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cwb_data_store.sv
module cwb_data_store #(
  parameter int INDEX_W = 3,
  parameter int OFF_W   = 2,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] r_idx,
  input  logic [OFF_W-1:0]   r_off,
  output logic [DATA_W-1:0]  r_word,
  input  logic               we,
  input  logic [INDEX_W-1:0] w_idx,
  input  logic [OFF_W-1:0]   w_off,
  input  logic [DATA_W-1:0]  w_word
);
  localparam int WORDS = 1 << (INDEX_W + OFF_W);

  logic [DATA_W-1:0] words_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) words_q[{w_idx, w_off}] <= w_word;
  end

  assign r_word = words_q[{r_idx, r_off}];
endmodule

// File: rtl/cwb_bank_mem.sv
module cwb_bank_mem
  import cwb_pkg::*;
#(
  parameter int AW     = 15,
  parameter int MEM_AW = 10,
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_sel,
  output logic              conflict
);
  localparam int BANKS = 4;
  localparam int DEPTH = 1 << (MEM_AW - 2);
  localparam int CW    = $clog2(LAT + 1);

  logic [1:0]          sel;
  logic [MEM_AW-3:0]   row;
  logic [DATA_W-1:0]   bank_rd [BANKS];
  logic [CW-1:0]       busy    [BANKS];
  logic                unused_hi_bits;

  assign sel = req_addr[1:0];
  assign row = req_addr[MEM_AW-1:2];
  assign unused_hi_bits = ^req_addr[AW-1:MEM_AW];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++)
          store[i] <= DATA_W'(cwb_seed_word(32'(i * BANKS + b)));
        busy[b] <= '0;
      end else begin
        if (busy[b] != '0) busy[b] <= busy[b] - 1'b1;
        if (req_valid && sel == 2'(b)) begin
          busy[b] <= CW'(LAT - 1);
          if (req_we) store[row] <= req_wdata;
        end
      end
    end
    assign bank_rd[b] = store[row];
  end

  logic              pv [LAT];
  logic [DATA_W-1:0] pd [LAT];
  logic [1:0]        ps [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= req_valid && !req_we;
      for (int k = 1; k < LAT; k++) pv[k] <= pv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pd[0] <= bank_rd[sel];
    ps[0] <= sel;
    for (int k = 1; k < LAT; k++) begin
      pd[k] <= pd[k-1];
      ps[k] <= ps[k-1];
    end
  end

  assign rsp_valid = pv[LAT-1];
  assign rsp_data  = pd[LAT-1];
  assign rsp_sel   = ps[LAT-1];
  assign conflict  = req_valid && (busy[sel] != '0);

  // R9 the controller never targets a bank still occupied
  bank_free_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy[sel] == '0);
endmodule

// File: rtl/cwb_mem_system.sv
module cwb_mem_system
  import cwb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int INDEX_W = 3,
  parameter int MEM_AW  = 10,
  parameter int MEM_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              stall,
  output logic              cache_hit,
  output logic              err
);
  localparam int OFF_W = 2;
  localparam int TAG_W = ADDR_W - 1 - OFF_W - INDEX_W;
  localparam int WA_W  = ADDR_W - 1;

  cwb_state_e state;
  logic [1:0]         cnt;
  logic [INDEX_W-1:0] lat_idx;
  logic [OFF_W-1:0]   lat_off;
  logic [TAG_W-1:0]   lat_tag, vic_tag;
  logic               lat_wr;
  logic [DATA_W-1:0]  lat_wdata;

  logic [OFF_W-1:0]   in_off;
  logic [INDEX_W-1:0] in_idx;
  logic [TAG_W-1:0]   in_tag;
  assign in_off = addr[OFF_W:1];
  assign in_idx = addr[OFF_W+1 +: INDEX_W];
  assign in_tag = addr[ADDR_W-1 -: TAG_W];

  logic idle, req, bad, hit, take_hit, take_miss, idle_bad;
  logic ts_valid, ts_dirty;
  logic [TAG_W-1:0] ts_tag;
  logic ts_we, ts_wdirty;
  logic [INDEX_W-1:0] ts_widx;
  logic [TAG_W-1:0] ts_wtag;

  assign idle      = (state == ST_IDLE);
  assign req       = rd | wr;
  assign bad       = (rd & wr) | addr[0];
  assign hit       = ts_valid && (ts_tag == in_tag);
  assign idle_bad  = idle && req && bad;
  assign take_hit  = idle && req && !bad && hit;
  assign take_miss = idle && req && !bad && !hit;

  logic rsp_valid, mem_conflict, fill_last;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0] rsp_sel;
  assign fill_last = rsp_valid && (rsp_sel == 2'd3);

  cwb_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(idle ? in_idx : lat_idx),
    .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_tag(ts_tag),
    .we(ts_we), .w_idx(ts_widx), .w_tag(ts_wtag), .w_dirty(ts_wdirty)
  );

  assign ts_we     = (take_hit && wr) || fill_last;
  assign ts_widx   = idle ? in_idx : lat_idx;
  assign ts_wtag   = idle ? in_tag : lat_tag;
  assign ts_wdirty = idle ? 1'b1 : lat_wr;

  logic [DATA_W-1:0] ds_word, ds_wword;
  logic [OFF_W-1:0]  ds_roff, ds_woff;
  logic              ds_we;

  assign ds_roff  = (state == ST_WBACK) ? cnt : (idle ? in_off : lat_off);
  assign ds_we    = (take_hit && wr) || rsp_valid;
  assign ds_woff  = idle ? in_off : rsp_sel;
  assign ds_wword = idle ? wdata :
                    ((lat_wr && rsp_sel == lat_off) ? lat_wdata : rsp_data);

  cwb_data_store #(.INDEX_W(INDEX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .r_idx(idle ? in_idx : lat_idx), .r_off(ds_roff), .r_word(ds_word),
    .we(ds_we), .w_idx(idle ? in_idx : lat_idx), .w_off(ds_woff), .w_word(ds_wword)
  );

  logic              mreq_valid, mreq_we;
  logic [WA_W-1:0]   mreq_addr;
  assign mreq_valid = (state == ST_WBACK) || (state == ST_FILL);
  assign mreq_we    = (state == ST_WBACK);
  assign mreq_addr  = {(state == ST_WBACK) ? vic_tag : lat_tag, lat_idx, cnt};

  cwb_bank_mem #(.AW(WA_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .LAT(MEM_LAT)) u_mem (
    .clk(clk), .rst(rst),
    .req_valid(mreq_valid), .req_we(mreq_we), .req_addr(mreq_addr),
    .req_wdata(ds_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_sel(rsp_sel),
    .conflict(mem_conflict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take_miss) begin
          state <= (ts_valid && ts_dirty) ? ST_WBACK : ST_FILL;
          cnt   <= '0;
        end
        ST_WBACK: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_FILL;
        end
        ST_FILL: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_WAIT;
        end
        default: if (fill_last) state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take_miss) begin
      lat_idx   <= in_idx;
      lat_off   <= in_off;
      lat_tag   <= in_tag;
      lat_wr    <= wr;
      lat_wdata <= wdata;
      vic_tag   <= ts_tag;
    end
  end

  assign rdata     = (!idle && rsp_valid && lat_off == 2'd3) ? rsp_data : ds_word;
  assign done      = take_hit || fill_last;
  assign cache_hit = take_hit;
  assign stall     = !idle;
  assign err       = idle_bad || mem_conflict;

  // R7 stall drops only right after a completion
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> $past(done));

  // R9 a rejected request never completes
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !done);

  // R2 the hit flag only accompanies a completion
  hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cache_hit |-> done);

  // R8 the captured request is held for the whole stall
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && $past(stall)) |-> ($stable(lat_idx) && $stable(lat_tag) && $stable(lat_off)));

  // R4 refill words return back to back in word order
  refill_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_sel != 2'd3) |=> (rsp_valid && rsp_sel == $past(rsp_sel) + 2'd1));

  // R4 memory responses arrive only while a miss is in flight
  rsp_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> stall);
endmodule

// File: tb/cwb_mem_system_test.sv
module cwb_mem_system_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic done, stall, cache_hit, err;

  always #5 clk = ~clk;

  cwb_mem_system uut (
    .clk(clk), .rst(rst), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .stall(stall), .cache_hit(cache_hit), .err(err)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] shadow [1024];
  logic        rv [8];
  logic        rdty [8];
  logic [9:0]  rtag [8];

  function automatic logic [15:0] seed_of(input int w);
    logic [31:0] p;
    p = (32'(w) * 32'h9E37) ^ 32'h5A5A;
    return p[15:0];
  endfunction

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic is_wr, input logic [15:0] a, input logic [15:0] d);
    int wa, idx, n, exp_lat;
    logic [9:0] tg;
    logic exp_hit;
    wa  = int'(a[10:1]);
    idx = int'(a[5:3]);
    tg  = a[15:6];
    exp_hit = rv[idx] && rtag[idx] == tg;
    exp_lat = exp_hit ? 0 : ((rv[idx] && rdty[idx]) ? 12 : 8);
    @(negedge clk);
    rd = !is_wr; wr = is_wr; addr = a; wdata = d;
    #1;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      rd = 1'($urandom); wr = 1'($urandom);
      addr = 16'($urandom); wdata = 16'($urandom);
      n++;
      #1;
      // R8 stray inputs during stall raise no error
      check(err == 1'b0 && stall == 1'b1, "R8", int'(err), 0);
    end
    if (exp_hit)
      check(n == 0, is_wr ? "R3" : "R2", n, 0);
    else if (exp_lat == 12)
      check(n == 12, "R6", n, 12);
    else
      check(n == 8, is_wr ? "R5" : "R4", n, 8);
    check(cache_hit == exp_hit, exp_hit ? "R2" : "R4", int'(cache_hit), int'(exp_hit));
    if (!is_wr)
      check(rdata == shadow[wa], exp_lat == 12 ? "R6" : "R2", int'(rdata), int'(shadow[wa]));
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    #1;
    // R7 single-cycle done and stall released
    check(done == 1'b0 && stall == 1'b0, "R7", int'({done, stall}), 0);
    if (is_wr) shadow[wa] = d;
    rv[idx] = 1'b1;
    rtag[idx] = tg;
    rdty[idx] = exp_hit ? (rdty[idx] | is_wr) : is_wr;
  endtask

  task automatic bad_req(input logic r, input logic w, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d;
    #1;
    // R9 malformed request flagged, not completed
    check(err == 1'b1 && done == 1'b0, "R9", int'({err, done}), 2);
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    #1;
    check(err == 1'b0 && stall == 1'b0, "R9", int'({err, stall}), 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 1024; i++) shadow[i] = seed_of(i);
    for (int i = 0; i < 8; i++) begin
      rv[i] = 1'b0; rdty[i] = 1'b0; rtag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 quiet outputs after reset
    check({done, stall, err, cache_hit} == 4'b0, "R1", int'({done, stall, err, cache_hit}), 0);
    // R1 R10 first access misses and returns preset contents
    do_req(1'b0, 16'h0000, 16'h0);
    do_req(1'b0, 16'h0006, 16'h0);          // R2
    do_req(1'b1, 16'h0004, 16'hBEEF);       // R3
    do_req(1'b0, 16'h0004, 16'h0);          // R2 read back
    do_req(1'b1, 16'h0012, 16'h1234);       // R5 write miss slot 2
    do_req(1'b0, 16'h0012, 16'h0);
    do_req(1'b0, 16'h0010, 16'h0);
    do_req(1'b0, 16'h0040, 16'h0);          // R6 evict dirty slot 0
    do_req(1'b0, 16'h0004, 16'h0);          // R6 evicted store survives
    do_req(1'b0, 16'h0452, 16'h0);          // R6 evict dirty slot 2
    do_req(1'b0, 16'h0012, 16'h0);
    bad_req(1'b1, 1'b0, 16'h0013, 16'h0);   // R9 odd address
    bad_req(1'b1, 1'b1, 16'h0010, 16'hFFFF);// R9 both strobes
    do_req(1'b0, 16'h0010, 16'h0);          // R9 state untouched
    do_req(1'b0, 16'h0012, 16'h0);
    do_req(1'b1, 16'h07FE, 16'hA5A5);       // R10 top of memory
    do_req(1'b0, 16'h003E, 16'h0);
    do_req(1'b0, 16'h07FE, 16'h0);
    for (int k = 0; k < 400; k++) begin
      logic [4:0] t;
      logic [2:0] ix;
      logic [1:0] of;
      t  = ($urandom % 8 < 6) ? 5'($urandom % 3) : 5'($urandom);
      ix = 3'($urandom);
      of = 2'($urandom);
      do_req(1'($urandom % 3 == 0), {5'b0, t, ix, of, 1'b0}, 16'($urandom));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule